// File: doc/BRIEF.md
# Carry-Save Montgomery Modular Exponentiator

This block raises a message to an exponent modulo an odd modulus, all three of a parameterised width `W` (64 by default). The exponent is scanned from its most significant bit to its least. Every bit costs one squaring, and a set bit adds one multiplication by the message. Each of these products is a bit-serial Montgomery multiplication with radix 2 and R = 2^W. Inside a product, the running partial result never goes through a carry chain. It is held as a sum vector and a carry vector. Each cycle it passes through two rows of carry-save adders, which add the multiplicand bit term and the parity-correction multiple of the modulus. The pair is then shifted right by one bit. One carry-propagate addition and one conditional subtraction of the modulus finish each product.

The caller supplies the message, the exponent, the modulus and the constant R^2 mod N. The block moves the message into the Montgomery domain, forms R mod N as the starting accumulator and runs the exponent loop. A final multiplication by one brings the result back out of the Montgomery domain. Operands enter on a valid/ready handshake and the result leaves on another valid/ready handshake:
- An operand set is taken on any clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while the block is idle.
- Once `out_valid` rises, it stays high and `out_result` stays unchanged until the edge on which `out_ready` is high. A slow consumer therefore stalls the block without losing the result.

The caller must keep N odd, the message below N, and R^2 mod N below N.

Top module: `mexp_top`

## Requirements
- R1: `in_ready` is high exactly while the block is idle. An operand set is taken on an edge where `in_valid` and `in_ready` are both high, and `in_ready` is low from the following cycle until the result has been handed over.
- R2: For an odd N, a message M < N and any exponent E, the delivered `out_result` equals M^E mod N, and every internal Montgomery product is already reduced below N.
- R3: With E = 0, the result is 1 mod N. This is 1 for any N > 1 and 0 for N = 1.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_result` is unchanged. After the edge on which both are high, `out_valid` is low and `in_ready` is high.
- R5: After reset, `in_ready` is 1 and `out_valid` is 0, and the two are never high together.
- R6: `out_valid` rises exactly (W + 3 + popcount(E)) x (W + 3) clock cycles after the accepting edge. Each of the W + 3 + popcount(E) Montgomery multiplications takes W + 3 cycles from launch to the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand set offered |
| in_ready | output | 1 | Block idle, operand set will be taken |
| in_msg | input | W | Message M, below N |
| in_exp | input | W | Exponent E |
| in_mod | input | W | Odd modulus N |
| in_r2 | input | W | Constant R^2 mod N, with R = 2^W |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | W | M^E mod N |

## Verification
The hardest condition to reach from the ports is a carry-save pair whose two vectors both carry large values while the modulus is near 2^W. Only there does a wrong vector width or a lost parity bit show up. The stimulus reaches it with the all-ones modulus and an all-ones exponent, and with random moduli that usually have their top bit set, so every product runs near the 2N bound. Zero-exponent cases, including N = 1, exercise the domain-conversion path with no loop multiplications. A random stall pattern on `out_ready` holds results across many cycles.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TO_MONT,
    ST_TO_ONE,
    ST_SQUARE,
    ST_MULT,
    ST_FROM_MONT,
    ST_OUT
  } mexp_state_e;
endpackage

// File: rtl/mexp_csa_row.sv
module mexp_csa_row #(
  parameter int XW = 8
) (
  input  logic [XW-1:0] x,
  input  logic [XW-1:0] y,
  input  logic [XW-1:0] z,
  output logic [XW-1:0] s,
  output logic [XW-1:0] c
);
  assign c[0] = 1'b0;
  for (genvar i = 0; i < XW; i++) begin : g_bit
    assign s[i] = x[i] ^ y[i] ^ z[i];
    if (i < XW - 1) begin : g_carry
      assign c[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
  end
endmodule

// File: rtl/mexp_mont_mul.sv
module mexp_mont_mul #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int SW = W + 2;          // stored sum/carry width
  localparam int XW = W + 3;          // adder row width, exact for both rows
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  a_q, b_q, n_q;
  logic [SW-1:0] s_q, c_q;
  logic [CW-1:0] cnt;
  logic          run;

  logic [W-1:0]  ab_term, qn_term;
  logic          q_bit;
  logic [XW-1:0] s1, c1, s2, c2;
  logic [SW-1:0] full_sum, full_sub;

  // parity of S + C + a_i*B decides whether N is added
  assign ab_term = a_q[0] ? b_q : '0;
  assign q_bit   = s_q[0] ^ c_q[0] ^ (a_q[0] & b_q[0]);
  assign qn_term = q_bit ? n_q : '0;

  mexp_csa_row #(.XW(XW)) row_ab_i (
    .x({{(XW-SW){1'b0}}, s_q}),
    .y({{(XW-SW){1'b0}}, c_q}),
    .z({{(XW-W){1'b0}}, ab_term}),
    .s(s1),
    .c(c1)
  );

  mexp_csa_row #(.XW(XW)) row_qn_i (
    .x(s1),
    .y(c1),
    .z({{(XW-W){1'b0}}, qn_term}),
    .s(s2),
    .c(c2)
  );

  // single carry-propagate add and conditional subtraction at the end
  assign full_sum = s_q + c_q;
  assign full_sub = full_sum - {2'b00, n_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      n_q  <= '0;
      s_q  <= '0;
      c_q  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
      res  <= '0;
    end else if (start) begin
      a_q  <= a;
      b_q  <= b;
      n_q  <= n;
      s_q  <= '0;
      c_q  <= '0;
      cnt  <= '0;
      run  <= 1'b1;
      done <= 1'b0;
    end else if (run) begin
      if (cnt == CW'(W)) begin
        res  <= (full_sum >= {2'b00, n_q}) ? W'(full_sub) : W'(full_sum);
        done <= 1'b1;
        run  <= 1'b0;
      end else begin
        s_q  <= SW'(s2 >> 1);
        c_q  <= SW'(c2 >> 1);
        a_q  <= a_q >> 1;
        cnt  <= cnt + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/mexp_top.sv
module mexp_top
  import mexp_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_msg,
  input  logic [W-1:0] in_exp,
  input  logic [W-1:0] in_mod,
  input  logic [W-1:0] in_r2,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_result
);
  localparam int IW = $clog2(W);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  mexp_state_e   state;
  logic [W-1:0]  exp_q, mod_q, r2_q, mbar_q;
  logic [IW-1:0] bit_idx;
  logic          mm_start, mm_done;
  logic [W-1:0]  mm_a, mm_b, mm_res;
  logic          last_bit;

  assign in_ready = (state == ST_IDLE);
  assign last_bit = (bit_idx == '0);

  mexp_mont_mul #(.W(W)) mul_i (
    .clk(clk),
    .rst_n(rst_n),
    .start(mm_start),
    .a(mm_a),
    .b(mm_b),
    .n(mod_q),
    .done(mm_done),
    .res(mm_res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      exp_q      <= '0;
      mod_q      <= '0;
      r2_q       <= '0;
      mbar_q     <= '0;
      bit_idx    <= IW'(W - 1);
      mm_start   <= 1'b0;
      mm_a       <= '0;
      mm_b       <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      mm_start <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          exp_q    <= in_exp;
          mod_q    <= in_mod;
          r2_q     <= in_r2;
          bit_idx  <= IW'(W - 1);
          mm_a     <= in_msg;
          mm_b     <= in_r2;
          mm_start <= 1'b1;
          state    <= ST_TO_MONT;
        end
        ST_TO_MONT: if (mm_done) begin
          mbar_q   <= mm_res;
          mm_a     <= ONE;
          mm_b     <= r2_q;
          mm_start <= 1'b1;
          state    <= ST_TO_ONE;
        end
        ST_TO_ONE: if (mm_done) begin
          mm_a     <= mm_res;
          mm_b     <= mm_res;
          mm_start <= 1'b1;
          state    <= ST_SQUARE;
        end
        ST_SQUARE: if (mm_done) begin
          mm_a     <= mm_res;
          mm_start <= 1'b1;
          if (exp_q[bit_idx]) begin
            mm_b  <= mbar_q;
            state <= ST_MULT;
          end else if (last_bit) begin
            mm_b  <= ONE;
            state <= ST_FROM_MONT;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            mm_b    <= mm_res;
            state   <= ST_SQUARE;
          end
        end
        ST_MULT: if (mm_done) begin
          mm_a     <= mm_res;
          mm_start <= 1'b1;
          if (last_bit) begin
            mm_b  <= ONE;
            state <= ST_FROM_MONT;
          end else begin
            bit_idx <= bit_idx - 1'b1;
            mm_b    <= mm_res;
            state   <= ST_SQUARE;
          end
        end
        ST_FROM_MONT: if (mm_done) begin
          out_result <= mm_res;
          out_valid  <= 1'b1;
          state      <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mexp_top_chk.sv
module mexp_top_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic [W-1:0] mod_q,
  input logic [W-1:0] exp_q,
  input logic         mm_done,
  input logic [W-1:0] mm_res
);
  logic [31:0] lat_cnt;
  logic [31:0] lat_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_cnt <= '0;
    else if (in_valid && in_ready) lat_cnt <= '0;
    else lat_cnt <= lat_cnt + 1;
  end

  assign lat_exp = (32'(W) + 32'd3 + 32'($countones(exp_q))) * (32'(W) + 32'd3);

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r2_product_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    mm_done |-> (mm_res < mod_q || mod_q == {{(W-1){1'b0}}, 1'b1}));

  a_r2_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result < mod_q || mod_q == {{(W-1){1'b0}}, 1'b1}));

  a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid && in_ready));

  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == lat_exp));
endmodule

bind mexp_top mexp_top_chk #(.W(W)) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_result(out_result),
  .mod_q(mod_q),
  .exp_q(exp_q),
  .mm_done(mm_done),
  .mm_res(mm_res)
);

// File: tb/mexp_top_tb_top.sv
module mexp_top_tb_top;
  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_msg = '0, in_exp = '0, in_mod = '0, in_r2 = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_result;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;
  bit done_flag = 1'b0;

  typedef struct {
    logic [W-1:0] val;
    int           lat;
    int           acc_cyc;
    string        tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mexp_top #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_msg(in_msg), .in_exp(in_exp), .in_mod(in_mod), .in_r2(in_r2),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] got, input logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got=%0h expected=%0h", req, got, expv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] n);
    logic [2*W-1:0] p;
    p = ({{W{1'b0}}, a} * {{W{1'b0}}, b}) % {{W{1'b0}}, n};
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] n);
    logic [W-1:0] r;
    r = (n == 1) ? '0 : 1;
    for (int i = W - 1; i >= 0; i--) begin
      r = mulmod(r, r, n);
      if (e[i]) r = mulmod(r, m, n);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_r2(input logic [W-1:0] n);
    logic [2*W-1:0] r;
    r = ({{(2*W-1){1'b0}}, 1'b1} << W) % {{W{1'b0}}, n};
    return mulmod(r[W-1:0], r[W-1:0], n);
  endfunction

  // driver: offers one operand set and pushes the expected item
  task automatic run_op(input logic [W-1:0] m, input logic [W-1:0] e, input logic [W-1:0] n);
    item_t it;
    @(negedge clk);
    in_msg = m; in_exp = e; in_mod = n; in_r2 = ref_r2(n);
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk(!in_ready, "R1", {63'b0, in_ready}, '0);
    it.val = ref_pow(m, e, n);
    it.lat = (W + 3 + $countones(e)) * (W + 3);
    it.acc_cyc = cyc;
    it.tag = (e == 0) ? "R3" : "R2";
    sb.push_back(it);
    in_valid = 1'b0;
  endtask

  // consumer back-pressure pattern
  initial begin
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_mode ? (($urandom % 4) == 0) : 1'b1;
    end
  end

  // monitor
  initial begin
    bit ov_prev = 1'b0;
    bit stalled = 1'b0;
    bit r4_pend = 1'b0;
    logic [W-1:0] held = '0;
    item_t it;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (r4_pend) begin
          chk(!out_valid && in_ready, "R4", {62'b0, out_valid, in_ready}, 64'h1);
          r4_pend = 1'b0;
        end
        if (stalled) chk(out_valid && out_result == held, "R4", out_result, held);
        if (out_valid && !ov_prev) begin
          if (sb.size() > 0)
            chk((cyc - sb[0].acc_cyc) == sb[0].lat, "R6", W'(cyc - sb[0].acc_cyc), W'(sb[0].lat));
          else
            chk(1'b0, "R2", out_result, '0);
        end
        stalled = out_valid && !out_ready;
        held = out_result;
        if (out_valid && out_ready && sb.size() > 0) begin
          it = sb.pop_front();
          chk(out_result == it.val, it.tag, out_result, it.val);
          r4_pend = 1'b1;
        end
        ov_prev = out_valid;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired got=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [W-1:0] n, m;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid, "R5", {62'b0, in_ready, out_valid}, 64'h2);

    run_op(64'd5, 64'd0, 64'd97);                     // R3: 1
    run_op(64'd0, 64'd0, 64'd1);                      // R3: N = 1 gives 0
    run_op(64'd0, 64'd13, 64'd101);                   // R2: zero message
    n = 64'hF123_4567_89AB_CDEF;
    run_op(n - 1, 64'd2, n);                          // R2: (-1)^2 = 1
    n = 64'hFFFF_FFFF_FFFF_FFFF;
    run_op(64'h1234_5678_9ABC_DEF0, {W{1'b1}}, n);    // R2: widest modulus, all-ones exponent
    run_op(64'd1, 64'hDEAD_BEEF_0BAD_F00D, 64'hC000_0000_0000_0001); // R2: message one
    for (int k = 0; k < 8; k++) begin
      stall_mode = (k % 2) == 1;                      // R4: random stalls on odd runs
      n = {$urandom, $urandom} | 64'h1;
      if (n == 1) n = 3;
      m = {$urandom, $urandom} % n;
      run_op(m, {$urandom, $urandom}, n);
    end
    while (sb.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (4) @(negedge clk);
    done_flag = 1'b1;
    summary();
    $finish;
  end
endmodule